// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Stage

This block sits between an interrupt source stage and one processor. It keeps a single presentation slot. The slot holds the source number being offered to the processor, the priority of that source, and the processor's current priority threshold. It also keeps a request priority for an inter-processor interrupt (IPI). Interrupts arriving from the source stage compete for the slot. The more favoured one wins, and the lower number means the more favoured priority. Any loser, including a source that gets pushed out of the slot, goes back to the source stage as a reject strobe.

The processor side works through one-cycle command strobes. These set the threshold, set the IPI request priority, accept the presented interrupt, and signal end-of-interrupt. Toward the source stage the block emits three strobes, one cycle after the command that caused them: reject (with a source number), resend-request, and end-of-interrupt (with a source number). A level output tells the processor that something is presented. An IPI shares the slot with external sources and always uses source number 2.

Top module: `irq_presenter`

## Requirements
- R1: After reset the accept word is 0, meaning threshold 0 and no source. The processor interrupt output is low, no strobe is active, and the IPI request priority is 0xFF, which never presents.
- R2: An incoming interrupt whose priority is greater than or equal to the threshold (accept word bits 31:24) is rejected in the next cycle with its own number, and the slot does not change.
- R3: An incoming interrupt is rejected in the next cycle when a source is presented whose priority is less than or equal to the incoming priority. The slot does not change.
- R4: Any other incoming interrupt takes the slot. The number goes into accept word bits 23:0 and the output rises in the next cycle. A source that was presented before is rejected in that same cycle.
- R5: Writing an IPI request priority below the threshold while nothing is presented puts source 2 in the slot, with the written value as its priority, and raises the output.
- R6: Writing an IPI request priority below the threshold changes nothing while the presented source's priority is at or below the written value. Otherwise the presented source is rejected and replaced by source 2.
- R7: Writing a threshold below the old one removes a presented source whose priority is at or above the new threshold. The output drops and that source is rejected. Lowering the threshold otherwise only changes the threshold.
- R8: Writing a threshold at or above the old one while nothing is presented issues a resend request. Before that, source 2 is presented if the IPI request priority is below the new threshold.
- R9: During an accept strobe the accept word shows the full register. Afterwards the output is low, the register holds the old presented priority in bits 31:24 with source 0, and the presented priority becomes 0xFF.
- R10: End-of-interrupt loads the threshold from bits 31:24 of the supplied word and forwards bits 23:0 as the EOI source number in the next cycle. If nothing is presented, a resend follows as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_prio_set | input | 1 | Write threshold strobe |
| cmd_prio_val | input | 8 | New threshold |
| cmd_ipi_set | input | 1 | Write IPI request priority strobe |
| cmd_ipi_val | input | 8 | New IPI request priority |
| cmd_accept | input | 1 | Accept strobe |
| accept_word | output | 32 | Current register: threshold in bits 31:24, presented source in bits 23:0 |
| cmd_eoi | input | 1 | End-of-interrupt strobe |
| eoi_word | input | 32 | Threshold to restore (31:24) and source to retire (23:0) |
| in_valid | input | 1 | Incoming interrupt strobe from the source stage |
| in_src | input | 24 | Incoming source number |
| in_prio | input | 8 | Incoming priority |
| cpu_irq | output | 1 | Level interrupt to the processor |
| rej_valid | output | 1 | Reject strobe to the source stage |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Resend request to the source stage |
| eoi_out_valid | output | 1 | End-of-interrupt strobe to the source stage |
| eoi_out_src | output | 24 | Retired source number |

## Verification
A wrong presented priority does not show when it goes wrong. It shows later, when a competing interrupt is rejected or admitted against it, or when an accept copies it into the threshold byte. The scenarios therefore chain their commands and check the accept word after each step. A lost or misplaced reject appears on the reject strobe exactly one cycle after the command. An output level that disagrees with the slot appears in that same cycle.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_prio_set,
  input  logic [PRIO_W-1:0]        cmd_prio_val,
  input  logic                     cmd_ipi_set,
  input  logic [PRIO_W-1:0]        cmd_ipi_val,
  input  logic                     cmd_accept,
  output logic [PRIO_W+SRC_W-1:0]  accept_word,
  input  logic                     cmd_eoi,
  input  logic [PRIO_W+SRC_W-1:0]  eoi_word,
  input  logic                     in_valid,
  input  logic [SRC_W-1:0]         in_src,
  input  logic [PRIO_W-1:0]        in_prio,
  output logic                     cpu_irq,
  output logic                     rej_valid,
  output logic [SRC_W-1:0]         rej_src,
  output logic                     resend_req,
  output logic                     eoi_out_valid,
  output logic [SRC_W-1:0]         eoi_out_src
);
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cppr, pend_prio, mfrr;
  logic [SRC_W-1:0]  xisr;
  logic [PRIO_W-1:0] n_cppr, n_pp, n_mfrr;
  logic [SRC_W-1:0]  n_xisr, n_rej_src, n_eoi_src;
  logic              n_irq, n_rej, n_rs, n_eoi;
  logic              busy;
  logic [PRIO_W-1:0] eoi_prio;

  assign busy        = (xisr != '0);
  assign accept_word = {cppr, xisr};
  assign eoi_prio    = eoi_word[WORD_W-1:SRC_W];

  always_comb begin
    n_cppr = cppr; n_xisr = xisr; n_pp = pend_prio; n_mfrr = mfrr; n_irq = cpu_irq;
    n_rej = 1'b0; n_rej_src = '0; n_rs = 1'b0; n_eoi = 1'b0; n_eoi_src = '0;
    if (cmd_prio_set) begin
      n_cppr = cmd_prio_val;
      if (cmd_prio_val < cppr) begin
        if (busy && cmd_prio_val <= pend_prio) begin
          n_xisr = '0; n_pp = PRIO_NONE; n_irq = 1'b0;
          n_rej = 1'b1; n_rej_src = xisr;
        end
      end else if (!busy) begin
        n_rs = 1'b1;
        if (mfrr < cmd_prio_val) begin
          n_xisr = IPI_NUM; n_pp = mfrr; n_irq = 1'b1;
        end
      end
    end else if (cmd_ipi_set) begin
      n_mfrr = cmd_ipi_val;
      if (cmd_ipi_val < cppr && !(busy && pend_prio <= cmd_ipi_val)) begin
        if (busy) begin
          n_rej = 1'b1; n_rej_src = xisr;
        end
        n_xisr = IPI_NUM; n_pp = cmd_ipi_val; n_irq = 1'b1;
      end
    end else if (cmd_accept) begin
      n_cppr = pend_prio; n_xisr = '0; n_pp = PRIO_NONE; n_irq = 1'b0;
    end else if (cmd_eoi) begin
      n_cppr = eoi_prio;
      n_eoi = 1'b1; n_eoi_src = eoi_word[SRC_W-1:0];
      if (!busy) begin
        n_rs = 1'b1;
        if (mfrr < eoi_prio) begin
          n_xisr = IPI_NUM; n_pp = mfrr; n_irq = 1'b1;
        end
      end
    end else if (in_valid) begin
      if (in_prio >= cppr || (busy && pend_prio <= in_prio)) begin
        n_rej = 1'b1; n_rej_src = in_src;
      end else begin
        if (busy) begin
          n_rej = 1'b1; n_rej_src = xisr;
        end
        n_xisr = in_src; n_pp = in_prio; n_irq = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr <= '0; xisr <= '0; pend_prio <= PRIO_NONE; mfrr <= PRIO_NONE;
      cpu_irq <= 1'b0; rej_valid <= 1'b0; rej_src <= '0;
      resend_req <= 1'b0; eoi_out_valid <= 1'b0; eoi_out_src <= '0;
    end else begin
      cppr <= n_cppr; xisr <= n_xisr; pend_prio <= n_pp; mfrr <= n_mfrr;
      cpu_irq <= n_irq; rej_valid <= n_rej; rej_src <= n_rej_src;
      resend_req <= n_rs; eoi_out_valid <= n_eoi; eoi_out_src <= n_eoi_src;
    end
  end

  a_r4_irq_tracks_slot: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (xisr != '0));

  a_r2_low_prio_bounced: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cmd_prio_set && !cmd_ipi_set && !cmd_accept && !cmd_eoi && in_prio >= cppr)
    |=> (rej_valid && rej_src == $past(in_src)));

  a_r5_ipi_presented: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ipi_set && !cmd_prio_set && cmd_ipi_val < cppr && xisr == '0)
    |=> (cpu_irq && xisr == IPI_NUM && pend_prio == $past(cmd_ipi_val)));

  a_r7_threshold_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_prio_set && cmd_prio_val < cppr && xisr != '0 && cmd_prio_val <= pend_prio)
    |=> (!cpu_irq && rej_valid && rej_src == $past(xisr)));

  a_r9_accept_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !cmd_prio_set && !cmd_ipi_set) |=> (!cpu_irq && pend_prio == PRIO_NONE));

  a_r10_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi && !cmd_prio_set && !cmd_ipi_set && !cmd_accept)
    |=> (eoi_out_valid && eoi_out_src == $past(eoi_word[SRC_W-1:0])));
endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_prio_set = 0, cmd_ipi_set = 0, cmd_accept = 0, cmd_eoi = 0, in_valid = 0;
  logic [7:0] cmd_prio_val = 0, cmd_ipi_val = 0, in_prio = 0;
  logic [31:0] eoi_word = 0, accept_word;
  logic [23:0] in_src = 0, rej_src, eoi_out_src;
  logic cpu_irq, rej_valid, resend_req, eoi_out_valid;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_prio_set(cmd_prio_set), .cmd_prio_val(cmd_prio_val),
    .cmd_ipi_set(cmd_ipi_set), .cmd_ipi_val(cmd_ipi_val),
    .cmd_accept(cmd_accept), .accept_word(accept_word),
    .cmd_eoi(cmd_eoi), .eoi_word(eoi_word),
    .in_valid(in_valid), .in_src(in_src), .in_prio(in_prio),
    .cpu_irq(cpu_irq), .rej_valid(rej_valid), .rej_src(rej_src),
    .resend_req(resend_req), .eoi_out_valid(eoi_out_valid), .eoi_out_src(eoi_out_src)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic release_all();
    @(negedge clk);
    cmd_prio_set = 0; cmd_ipi_set = 0; cmd_accept = 0; cmd_eoi = 0; in_valid = 0;
  endtask

  task automatic set_cppr(input logic [7:0] v);
    @(negedge clk); cmd_prio_set = 1; cmd_prio_val = v; release_all();
  endtask
  task automatic set_mfrr(input logic [7:0] v);
    @(negedge clk); cmd_ipi_set = 1; cmd_ipi_val = v; release_all();
  endtask
  task automatic send_irq(input logic [23:0] s, input logic [7:0] p);
    @(negedge clk); in_valid = 1; in_src = s; in_prio = p; release_all();
  endtask
  task automatic send_eoi(input logic [31:0] w);
    @(negedge clk); cmd_eoi = 1; eoi_word = w; release_all();
  endtask
  task automatic do_accept(input string tag, input logic [31:0] exp);
    @(negedge clk); cmd_accept = 1;
    #1 chk(tag, accept_word, exp);
    release_all();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 word", accept_word, 0);
    chk("R1 irq", cpu_irq, 0);
    chk("R1 strobes", {rej_valid, resend_req, eoi_out_valid}, 0);
    set_cppr(8'hFF);
    chk("R8 resend on raise", resend_req, 1);
    chk("R1 mfrr idle no ipi", accept_word, 32'hFF000000);
  endtask

  task automatic t_low_prio();
    do_reset();
    set_cppr(8'h10);
    send_irq(24'h55, 8'h10);
    chk("R2 reject", rej_valid, 1);
    chk("R2 reject src", rej_src, 24'h55);
    chk("R2 slot kept", accept_word, 32'h10000000);
    chk("R2 irq low", cpu_irq, 0);
  endtask

  task automatic t_present();
    do_reset();
    set_cppr(8'hFF);
    send_irq(24'h100, 8'h05);
    chk("R4 irq", cpu_irq, 1);
    chk("R4 word", accept_word, 32'hFF000100);
    chk("R4 no reject", rej_valid, 0);
    send_irq(24'h200, 8'h05);
    chk("R3 reject", {rej_valid, 8'h0, rej_src}, {1'b1, 8'h0, 24'h200});
    chk("R3 slot kept", accept_word, 32'hFF000100);
    send_irq(24'h300, 8'h03);
    chk("R4 displace reject", {rej_valid, 8'h0, rej_src}, {1'b1, 8'h0, 24'h100});
    chk("R4 new word", accept_word, 32'hFF000300);
    do_accept("R9 read", 32'hFF000300);
    chk("R9 irq low", cpu_irq, 0);
    chk("R9 word after", accept_word, 32'h03000000);
    send_eoi(32'hFF000300);
    chk("R10 eoi strobe", {eoi_out_valid, 8'h0, eoi_out_src}, {1'b1, 8'h0, 24'h300});
    chk("R10 resend", resend_req, 1);
    chk("R10 cppr restored", accept_word, 32'hFF000000);
  endtask

  task automatic t_ipi();
    do_reset();
    set_cppr(8'hFF);
    set_mfrr(8'h20);
    chk("R5 irq", cpu_irq, 1);
    chk("R5 word", accept_word, 32'hFF000002);
    set_mfrr(8'h30);
    chk("R6 no change", accept_word, 32'hFF000002);
    chk("R6 no reject", rej_valid, 0);
    send_irq(24'h40, 8'h10);
    chk("R4 ipi displaced", {rej_valid, 8'h0, rej_src}, {1'b1, 8'h0, 24'h2});
    chk("R4 word", accept_word, 32'hFF000040);
    set_mfrr(8'h08);
    chk("R6 displace", {rej_valid, 8'h0, rej_src}, {1'b1, 8'h0, 24'h40});
    chk("R6 word", accept_word, 32'hFF000002);
    do_accept("R9 ipi read", 32'hFF000002);
    chk("R9 prio moved", accept_word, 32'h08000000);
  endtask

  task automatic t_cppr_drop();
    do_reset();
    set_cppr(8'hFF);
    send_irq(24'h77, 8'h40);
    set_cppr(8'h40);
    chk("R7 reject", {rej_valid, 8'h0, rej_src}, {1'b1, 8'h0, 24'h77});
    chk("R7 irq low", cpu_irq, 0);
    chk("R7 word", accept_word, 32'h40000000);
    set_cppr(8'h30);
    chk("R7 plain drop", {rej_valid, resend_req}, 0);
    chk("R7 plain word", accept_word, 32'h30000000);
  endtask

  task automatic t_eoi_ipi();
    do_reset();
    set_cppr(8'hFF);
    set_mfrr(8'h50);
    do_accept("R9 ipi", 32'hFF000002);
    chk("R9 word", accept_word, 32'h50000000);
    send_eoi(32'hFF000002);
    chk("R10 eoi src", eoi_out_src, 24'h2);
    chk("R10 resend", resend_req, 1);
    chk("R8 ipi re-presented", {cpu_irq, accept_word}, {1'b1, 32'hFF000002});
  endtask

  initial begin
    t_reset();
    t_low_prio();
    t_present();
    t_ipi();
    t_cppr_drop();
    t_eoi_ipi();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule